// File: doc/BRIEF.md
# Multi-Channel Prescaled PWM Bank

This block is a bank of identical pulse-width channels behind a simple word-wide write/read port. Every channel has its own clock prescaler, its own up-counter and two programmable compare points. In each period the pin moves to a programmable "active" level when the counter reaches the first point and goes back to a programmable "inactive" level at the second point. One control word turns channels on and off. Writing a 1 through one alias address switches a channel on, and writing a 1 through a second alias switches it off. Neither alias needs a read-modify-write.

Settings are double-buffered. Software first writes the compare word of a channel and then its period/configuration word. The period write seals the pair into a pending slot. The running channel adopts the pair only when its counter wraps, so the waveform never shows a mixed or truncated period. A disabled channel adopts pending settings at once, so its idle level follows the latest configuration.

Top module: `pwm_bank`

## Requirements
- R1: After reset every pwm_o bit is low, the control word at 0x00 reads 0 and every channel register reads 0.
- R2: The word at 0x00 reads the enable bits, with bit n for channel n. A write to 0x04 enables each channel whose data bit is 1. A write to 0x08 disables each channel whose data bit is 1. Bits written as 0 leave their channel unchanged, and a write to 0x00 changes nothing.
- R3: For channel n (counting from 0), the compare word sits at byte address 0x20*(n+1) and the period word at 0x20*(n+1)+0x10. Reads return the last value written. Bits 31:23 of a period word read as 0.
- R4: Period word bits 22:20 hold a divide code. Codes 0 to 7 divide the clock by 1, 2, 4, 8, 16, 64, 256 and 1024, and the counter steps once per divided tick.
- R5: The counter runs from 0 to P, where P is period bits 15:0, and then returns to 0, so one period lasts P+1 ticks. A disabled channel holds its counter at 0. After the enabling write the count is 0 and steps to 1 after D clocks, where D is the divide ratio.
- R6: Compare bits 15:0 give the on point and bits 31:16 give the off point. The pin is at the active level while on <= count < off.
- R7: An off point of 0 keeps the pin inactive for the whole period. An off point equal to or above P keeps the pin active from the on point through count P.
- R8: Period bits 17:16 choose the active level and bits 19:18 choose the inactive level. Code 3 drives high and any other code drives low. A disabled channel drives its inactive level from the cycle after the disabling write.
- R9: An enabled channel loads pending settings only at the clock edge where its count wraps from P to 0. A disabled channel loads them on the clock after the period write.
- R10: A period write commits itself together with the compare value held at that moment. A compare write on its own changes no output. A compare write made after a commit but before the load leaves the pending pair unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe, sampled at the rising edge |
| addr_i | input | AW (8) | Byte address for writes and reads |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pwm_o | output | NCH (4) | One output pin per channel |

## Verification
Some properties are checked on every clock. The set and clear aliases must act on exactly the bits written. A counter must never pass its working period, must stay at zero while disabled and must step by one on each divided tick inside a period. Working settings must not change mid-period, and a disabled channel or a zero off point must show the inactive level. Other behaviour is shown only by the bench's timed scenarios. These cover the exact waveform shape for each divide code, the cycle on which a double-buffered update first appears, and the rule that a stray compare write after a commit is ignored. They also cover the address map and read-back.

// File: rtl/pwm_bank_pkg.sv
`timescale 1ns/1ps
package pwm_bank_pkg;

  localparam int CNT_W = 16;
  localparam int PRE_W = 10;
  localparam logic [1:0] LVL_HIGH = 2'b11;

  typedef struct packed {
    logic [CNT_W-1:0] off_cnt;
    logic [CNT_W-1:0] on_cnt;
  } duty_t;

  typedef struct packed {
    logic [2:0]       div_code;
    logic [1:0]       idle_lvl;
    logic [1:0]       act_lvl;
    logic [CNT_W-1:0] per_cnt;
  } per_cfg_t;

  // ratios 1,2,4,8,16 then 64,256,1024: shift = code below 5, else 2*code-4
  function automatic logic [PRE_W-1:0] div_limit(input logic [2:0] code);
    logic [3:0] sh;
    sh = (code < 3'd5) ? {1'b0, code} : ({code, 1'b0} - 4'd4);
    return PRE_W'((32'd1 << sh) - 32'd1);
  endfunction

endpackage

// File: rtl/pwm_bank_regs.sv
`timescale 1ns/1ps
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic [NCH-1:0]      en_o,
  output duty_t [NCH-1:0]     duty_o,
  output per_cfg_t            cfg_wr_o,
  output logic [NCH-1:0]      commit_o
);

  localparam int STRIDE  = 32;
  localparam int PER_OFS = 16;
  localparam int CFG_W   = $bits(per_cfg_t);
  localparam logic [AW-1:0] CTRL_A = '0;
  localparam logic [AW-1:0] SET_A  = AW'(4);
  localparam logic [AW-1:0] CLR_A  = AW'(8);

  logic [NCH-1:0]     en_q;
  logic [NCH-1:0]     hit_duty, hit_per;
  duty_t [NCH-1:0]    duty_q;
  per_cfg_t [NCH-1:0] per_q;

  function automatic logic [AW-1:0] duty_addr(input int n);
    return AW'(STRIDE * (n + 1));
  endfunction

  function automatic logic [AW-1:0] per_addr(input int n);
    return AW'(STRIDE * (n + 1) + PER_OFS);
  endfunction

  always_comb begin
    for (int n = 0; n < NCH; n++) begin
      hit_duty[n] = we_i && (addr_i == duty_addr(n));
      hit_per[n]  = we_i && (addr_i == per_addr(n));
    end
  end

  assign cfg_wr_o = per_cfg_t'(wdata_i[CFG_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      duty_q <= '0;
      per_q  <= '0;
    end else begin
      if (we_i && addr_i == SET_A)      en_q <= en_q | wdata_i[NCH-1:0];
      else if (we_i && addr_i == CLR_A) en_q <= en_q & ~wdata_i[NCH-1:0];
      for (int n = 0; n < NCH; n++) begin
        if (hit_duty[n]) duty_q[n] <= duty_t'(wdata_i);
        if (hit_per[n])  per_q[n]  <= cfg_wr_o;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_A) rdata_o = 32'(en_q);
    for (int n = 0; n < NCH; n++) begin
      if (addr_i == duty_addr(n)) rdata_o = duty_q[n];
      if (addr_i == per_addr(n))  rdata_o = 32'(per_q[n]);
    end
  end

  assign en_o     = en_q;
  assign duty_o   = duty_q;
  assign commit_o = hit_per;

endmodule

// File: rtl/pwm_bank_presc.sv
`timescale 1ns/1ps
module pwm_bank_presc
  import pwm_bank_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [2:0] div_code_i,
  output logic       tick_o
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;

  assign lim    = div_limit(div_code_i);
  assign tick_o = run_i && (pre_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (!run_i || tick_o)  pre_q <= '0;
    else                        pre_q <= pre_q + 1'b1;
  end

endmodule

// File: rtl/pwm_bank_chan.sv
`timescale 1ns/1ps
module pwm_bank_chan
  import pwm_bank_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  duty_t            duty_i,
  input  per_cfg_t         cfg_wr_i,
  input  logic             commit_i,
  output logic             pwm_o,
  output logic             tick_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] wk_per_o,
  output logic [CNT_W-1:0] wk_off_o,
  output logic [1:0]       wk_idle_o
);

  duty_t            stg_duty_q, wk_duty_q;
  per_cfg_t         stg_cfg_q, wk_cfg_q;
  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick, wrap, load, in_win;
  logic [1:0]       lvl;

  pwm_bank_presc u_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (en_i),
    .div_code_i (wk_cfg_q.div_code),
    .tick_o     (tick)
  );

  assign wrap = tick && (cnt_q == wk_cfg_q.per_cnt);
  assign load = pend_q && (!en_i || wrap);

  // staged pair sealed by the period write, adopted at the wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      stg_duty_q <= '0;
      stg_cfg_q  <= '0;
      wk_duty_q  <= '0;
      wk_cfg_q   <= '0;
    end else begin
      pend_q <= commit_i | (pend_q & ~load);
      if (commit_i) begin
        stg_duty_q <= duty_i;
        stg_cfg_q  <= cfg_wr_i;
      end
      if (load) begin
        wk_duty_q <= stg_duty_q;
        wk_cfg_q  <= stg_cfg_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (wrap)    cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    in_win = (wk_duty_q.off_cnt != '0) &&
             (cnt_q >= wk_duty_q.on_cnt) &&
             ((wk_duty_q.off_cnt >= wk_cfg_q.per_cnt) || (cnt_q < wk_duty_q.off_cnt));
    lvl    = (en_i && in_win) ? wk_cfg_q.act_lvl : wk_cfg_q.idle_lvl;
  end

  assign pwm_o     = (lvl == LVL_HIGH);
  assign tick_o    = tick;
  assign cnt_o     = cnt_q;
  assign wk_per_o  = wk_cfg_q.per_cnt;
  assign wk_off_o  = wk_duty_q.off_cnt;
  assign wk_idle_o = wk_cfg_q.idle_lvl;

endmodule

// File: rtl/pwm_bank.sv
`timescale 1ns/1ps
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [31:0]    wdata_i,
  output logic [31:0]    rdata_o,
  output logic [NCH-1:0] pwm_o
);

  logic [NCH-1:0]            en_w, commit_w, tick_w;
  duty_t [NCH-1:0]           duty_w;
  per_cfg_t                  cfg_wr_w;
  logic [NCH-1:0][CNT_W-1:0] cnt_w, per_w, off_w;
  logic [NCH-1:0][1:0]       idle_w;

  pwm_bank_regs #(.NCH(NCH), .AW(AW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .en_o     (en_w),
    .duty_o   (duty_w),
    .cfg_wr_o (cfg_wr_w),
    .commit_o (commit_w)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    pwm_bank_chan u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_w[n]),
      .duty_i    (duty_w[n]),
      .cfg_wr_i  (cfg_wr_w),
      .commit_i  (commit_w[n]),
      .pwm_o     (pwm_o[n]),
      .tick_o    (tick_w[n]),
      .cnt_o     (cnt_w[n]),
      .wk_per_o  (per_w[n]),
      .wk_off_o  (off_w[n]),
      .wk_idle_o (idle_w[n])
    );
  end

endmodule

// File: rtl/pwm_bank_checker.sv
`timescale 1ns/1ps
module pwm_bank_checker
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      we_i,
  input logic [AW-1:0]             addr_i,
  input logic [NCH-1:0]            set_bits_i,
  input logic [NCH-1:0]            pwm_i,
  input logic [NCH-1:0]            en_i,
  input logic [NCH-1:0]            tick_i,
  input logic [NCH-1:0][CNT_W-1:0] cnt_i,
  input logic [NCH-1:0][CNT_W-1:0] per_i,
  input logic [NCH-1:0][CNT_W-1:0] off_i,
  input logic [NCH-1:0][1:0]       idle_i
);

  a_r2_set_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(4)) |=> ((en_i & $past(set_bits_i)) == $past(set_bits_i)));

  a_r2_clr_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(8)) |=> ((en_i & $past(set_bits_i)) == '0));

  for (genvar n = 0; n < NCH; n++) begin : g_chk
    a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_i[n] <= per_i[n]);

    a_r5_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[n] |=> (cnt_i[n] == '0));

    a_r5_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i[n] && tick_i[n] && cnt_i[n] < per_i[n]) |=> (cnt_i[n] == $past(cnt_i[n]) + 1'b1));

    a_r7_zero_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i[n] && off_i[n] == '0) |-> (pwm_i[n] == (idle_i[n] == LVL_HIGH)));

    a_r8_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[n] |-> (pwm_i[n] == (idle_i[n] == LVL_HIGH)));

    a_r9_hold_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i[n] && !(tick_i[n] && cnt_i[n] == per_i[n]))
        |=> ($stable(per_i[n]) && $stable(off_i[n])));
  end

endmodule

bind pwm_bank pwm_bank_checker #(.NCH(NCH), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .set_bits_i (wdata_i[NCH-1:0]),
  .pwm_i      (pwm_o),
  .en_i       (en_w),
  .tick_i     (tick_w),
  .cnt_i      (cnt_w),
  .per_i      (per_w),
  .off_i      (off_w),
  .idle_i     (idle_w)
);

// File: tb/pwm_bank_test.sv
`timescale 1ns/1ps
module pwm_bank_test;

  localparam int NCH = 4;
  localparam int AW  = 8;
  localparam logic [AW-1:0] CTRL_A = 8'h00;
  localparam logic [AW-1:0] SET_A  = 8'h04;
  localparam logic [AW-1:0] CLR_A  = 8'h08;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           we = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [31:0]    wdata = '0;
  logic [31:0]    rdata;
  logic [NCH-1:0] pwm;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  int    q_cyc[$];
  int    q_ch[$];
  bit    q_val[$];
  string q_tag[$];

  pwm_bank #(.NCH(NCH), .AW(AW)) uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .pwm_o   (pwm)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // requirement-level model pieces
  function automatic int div_of(input int code);
    case (code)
      0: return 1;    1: return 2;    2: return 4;   3: return 8;
      4: return 16;   5: return 64;   6: return 256; default: return 1024;
    endcase
  endfunction

  function automatic bit lvl_hi(input int code);
    return code == 3;
  endfunction

  function automatic bit exp_pin(input int cnt, input int on, input int off,
                                 input int per, input int act, input int idle);
    bit active;
    active = (off != 0) && (cnt >= on) && ((off >= per) || (cnt < off));
    return active ? lvl_hi(act) : lvl_hi(idle);
  endfunction

  function automatic logic [AW-1:0] duty_a(input int ch);
    return AW'(32 * (ch + 1));
  endfunction

  function automatic logic [AW-1:0] per_a(input int ch);
    return AW'(32 * (ch + 1) + 16);
  endfunction

  function automatic logic [31:0] mkper(input int code, input int idle, input int act, input int per);
    return {9'd0, code[2:0], idle[1:0], act[1:0], per[15:0]};
  endfunction

  task automatic push(input int c, input int ch, input bit v, input string t);
    q_cyc.push_back(c); q_ch.push_back(ch); q_val.push_back(v); q_tag.push_back(t);
  endtask

  task automatic push_win(input int start, input int len, input int ch, input int on, input int off,
                          input int per, input int code, input int act, input int idle, input string t);
    for (int j = 0; j < len; j++)
      push(start + j, ch, exp_pin((j / div_of(code)) % (per + 1), on, off, per, act, idle), t);
  endtask

  // monitor: pops expected items as their cycle comes up
  always @(negedge clk) begin
    int c, ch;
    bit v;
    string t;
    while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      c = q_cyc.pop_front(); ch = q_ch.pop_front(); v = q_val.pop_front(); t = q_tag.pop_front();
      n_chk++;
      if (c != cyc) begin
        n_bad++;
        $display("FAIL %s: item for cycle %0d seen at %0d, got - exp %0b", t, c, cyc, v);
      end else if (pwm[ch] !== v) begin
        n_bad++;
        $display("FAIL %s: ch%0d cycle %0d got %0b exp %0b", t, ch, cyc, pwm[ch], v);
      end
    end
  end

  task automatic check(input bit ok, input string t, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h exp %0h", t, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  // write lands on edge number c
  task automatic wr_at(input int c, input logic [AW-1:0] a, input logic [31:0] d, input string t);
    while (cyc < c - 1) @(negedge clk);
    if (cyc != c - 1) check(1'b0, t, cyc, c - 1);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp, input string t);
    @(negedge clk);
    addr = a;
    #1;
    check(rdata === exp, t, rdata, exp);
  endtask

  task automatic run_case(input int ch, input int on, input int off, input int per, input int code,
                          input int act, input int idle, input string t);
    int e, len, x;
    wr(duty_a(ch), {off[15:0], on[15:0]});
    wr(per_a(ch), mkper(code, idle, act, per));
    repeat (2) @(negedge clk);
    len = div_of(code) * (per + 1) * 2 + 3;
    e = cyc + 3;
    push_win(e, len, ch, on, off, per, code, act, idle, t);
    x = e + len + 1;
    push(x, ch, lvl_hi(idle), "R8");
    push(x + 1, ch, lvl_hi(idle), "R8");
    wr_at(e, SET_A, 32'(1 << ch), t);
    wr_at(x, CLR_A, 32'(1 << ch), "R8");
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got cycle %0d exp completion", cyc);
    finish_run();
  end

  initial begin
    int e, w, x;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pwm === '0, "R1 pins low in reset", 32'(pwm), 0);
    rst_n = 1'b1;
    rd_chk(CTRL_A, 0, "R1 ctrl");
    rd_chk(duty_a(0), 0, "R1 duty");
    rd_chk(per_a(3), 0, "R1 period");
    check(pwm === '0, "R1 pins low after reset", 32'(pwm), 0);

    // R3 address map and read-back
    wr(duty_a(1), 32'hABCD_1234);
    wr(per_a(3), 32'hFFFF_FFFF);
    rd_chk(duty_a(1), 32'hABCD_1234, "R3 duty read");
    rd_chk(per_a(3), 32'h007F_FFFF, "R3 period upper bits zero");
    rd_chk(duty_a(0), 0, "R3 stride isolation");
    wr(per_a(3), mkper(0, 2, 3, 4));

    // R2 write to 0x00 ignored
    wr(CTRL_A, 32'hF);
    rd_chk(CTRL_A, 0, "R2 ctrl write ignored");

    // R9 disabled channel loads on the clock after the period write
    w = cyc + 3;
    push(w, 0, 1'b0, "R9");
    push(w + 1, 0, 1'b1, "R9");
    wr_at(w - 1, duty_a(0), 32'h0002_0001, "R9");
    wr_at(w, per_a(0), mkper(0, 3, 2, 4), "R9");
    repeat (2) @(negedge clk);
    w = cyc + 2;
    push(w + 1, 0, 1'b0, "R8 idle code 2 low");
    wr_at(w, per_a(0), mkper(0, 2, 3, 4), "R8");
    repeat (2) @(negedge clk);

    // R5 and R6: plain window, divide 1
    run_case(0, 2, 5, 7, 0, 3, 2, "R6");
    // R4: several divide codes
    run_case(2, 1, 3, 4, 2, 3, 2, "R4 div4");
    run_case(1, 0, 1, 2, 5, 3, 2, "R4 div64");
    run_case(3, 0, 1, 1, 7, 3, 2, "R4 div1024");
    run_case(2, 1, 2, 1, 1, 3, 2, "R5 div2");
    // R7 corners
    run_case(0, 0, 0, 5, 0, 3, 2, "R7 off zero");
    run_case(0, 0, 9, 5, 0, 3, 2, "R7 off above period");
    run_case(1, 3, 16'hFFFF, 5, 0, 3, 2, "R7 on mid off max");
    run_case(0, 0, 1, 0, 0, 3, 2, "R5 period zero");
    // R8 inverse polarity and non-3 codes
    run_case(2, 1, 4, 6, 0, 2, 3, "R8 inverse");
    run_case(3, 2, 4, 5, 0, 3, 0, "R8 idle code 0");

    // R9 / R10 double buffering on channel 1
    wr(duty_a(1), {16'd2, 16'd0});
    wr(per_a(1), mkper(0, 2, 3, 3));
    repeat (2) @(negedge clk);
    e = cyc + 3;
    push_win(e, 8, 1, 0, 2, 3, 0, 3, 2, "R9 old pair until wrap");
    push_win(e + 8, 12, 1, 1, 3, 5, 0, 3, 2, "R9 new pair from wrap");
    push_win(e + 20, 13, 1, 0, 1, 3, 0, 3, 2, "R10 committed pair kept");
    x = e + 34;
    push(x, 1, 1'b0, "R8");
    wr_at(e, SET_A, 32'h2, "R9");
    wr_at(e + 5, duty_a(1), {16'd3, 16'd1}, "R10");
    wr_at(e + 6, per_a(1), mkper(0, 2, 3, 5), "R9");
    wr_at(e + 15, duty_a(1), {16'd1, 16'd0}, "R10");
    wr_at(e + 16, per_a(1), mkper(0, 2, 3, 3), "R10");
    wr_at(e + 17, duty_a(1), {16'd3, 16'd0}, "R10");
    wr_at(x, CLR_A, 32'h2, "R8");
    rd_chk(duty_a(1), {16'd3, 16'd0}, "R10 shadow holds late write");
    repeat (2) @(negedge clk);

    // R2 set/clear aliases
    wr(SET_A, 32'h5);
    rd_chk(CTRL_A, 32'h5, "R2 set");
    wr(SET_A, 32'h0);
    rd_chk(CTRL_A, 32'h5, "R2 zero bits on set");
    wr(CLR_A, 32'h1);
    rd_chk(CTRL_A, 32'h4, "R2 clear one");
    wr(CLR_A, 32'h0);
    rd_chk(CTRL_A, 32'h4, "R2 zero bits on clear");
    wr(CLR_A, 32'h4);
    rd_chk(CTRL_A, 32'h0, "R2 clear all");

    repeat (4) @(negedge clk);
    check(q_cyc.size() == 0, "R5 scoreboard drained", q_cyc.size(), 0);
    finish_run();
  end

endmodule